// File: doc/BRIEF.md
# Strobed Serial Bus Write Master

This block sits on a CPU register bus and drives a write-only serial link to the modules of an instrument. Software sends a module one bit per CPU write. It first places the bit in the low bit of an output holding register, which drives the shared serial data line. It then writes a strobe address, and the block pulls the active-low shift clock low for a fixed number of CPU clocks. Every module on the link shifts in one bit on each such strobe.

After the last bit, software places a 4-bit module address in the upper nibble of the holding register. It then writes a load address, and the block produces an active-low load pulse of the same length. Logic downstream qualifies this pulse with the address lines so that only the addressed module latches its shifted data.

A separate control register drives three steady outputs: a gate for interval-timer channel 0, a single-sweep trigger and an enable for the audio tone timer. Only one pulse can run at a time. A strobe or load command that arrives while a pulse is active is dropped, and a sticky status flag records it. Software can read the holding, control and status registers back.

Top module: `serial_bus_writer`

## Requirements
- R1: After reset the holding and control registers are zero, the collision flag is clear, shiftClkN and loadN are high, and serData, modAddr, timer0Gate, sweepTrig and audioEn are all 0.
- R2: A write to address 0 stores all 8 data bits in the holding register. serData follows bit 0 and modAddr follows bits 7:4 from the next cycle on. A read of address 0 returns the stored byte.
- R3: When idle, a write to address 1 drives shiftClkN low for exactly PULSE_LEN (default 2) cycles, starting in the cycle after the write. shiftClkN then returns high.
- R4: When idle, a write to address 2 drives loadN low for exactly PULSE_LEN cycles, starting in the cycle after the write. loadN then returns high.
- R5: A write to address 3 stores data bits 2:0 in the control register. Bit 0 drives timer0Gate, bit 1 drives sweepTrig and bit 2 drives audioEn. A read of address 3 returns the three bits with bits 7:3 zero.
- R6: shiftClkN and loadN are never low in the same cycle.
- R7: A write to address 1 or 2 while a pulse is active neither starts a pulse nor lengthens the current one. It sets the collision flag.
- R8: A read of address 4 returns status: bit 0 is high while a pulse is active, and bit 1 is the collision flag. A write to address 4 with data bit 1 set clears the flag. A collision in the same cycle keeps the flag set.
- R9: Writes to addresses 5 to 7 change no register and no output. Reads of addresses 1, 2 and 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| serData | output | 1 | Serial data line (holding bit 0) |
| shiftClkN | output | 1 | Active-low shift strobe |
| modAddr | output | 4 | Module address (holding bits 7:4) |
| loadN | output | 1 | Active-low load pulse |
| timer0Gate | output | 1 | Gate for interval-timer channel 0 |
| sweepTrig | output | 1 | Single-sweep trigger |
| audioEn | output | 1 | Audio tone timer enable |

## Verification
The assertions assume that busWr is a one-cycle strobe with busAddr valid in the same cycle, and that PULSE_LEN is at least 1. The stimulus drives each write for exactly one cycle, starting at a falling clock edge, and it never holds busWr across two edges. It also issues commands on purpose in the first and last cycle of an active pulse, so that the assumption about busy timing is exercised at both ends.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int CTRL_W = 3;
  localparam int MOD_W  = 4;

  localparam logic [ADDR_W-1:0] ADR_HOLD  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SHIFT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd4;

  typedef enum logic [1:0] {PS_IDLE, PS_SHIFT, PS_LOAD} pulseState_t;

  typedef struct packed {
    logic holdWe;
    logic ctrlWe;
    logic flagSet;
    logic flagClr;
  } sbwStrobes_t;
endpackage

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output sbwStrobes_t       strb,
  output logic              shiftClkN,
  output logic              loadN,
  output logic              busy
);
  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  pulseState_t state;
  logic [CNT_W-1:0] cnt;
  logic cmdShift, cmdLoad;

  assign cmdShift = busWr && (busAddr == ADR_SHIFT);
  assign cmdLoad  = busWr && (busAddr == ADR_LOAD);
  assign busy     = (state != PS_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PS_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        PS_IDLE: begin
          if (cmdShift) begin
            state <= PS_SHIFT;
            cnt   <= CNT_W'(PULSE_LEN - 1);
          end else if (cmdLoad) begin
            state <= PS_LOAD;
            cnt   <= CNT_W'(PULSE_LEN - 1);
          end
        end
        default: begin
          if (cnt == '0) state <= PS_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign shiftClkN = (state != PS_SHIFT);
  assign loadN     = (state != PS_LOAD);

  always_comb begin
    strb.holdWe  = busWr && (busAddr == ADR_HOLD);
    strb.ctrlWe  = busWr && (busAddr == ADR_CTRL);
    strb.flagSet = busy && (cmdShift || cmdLoad);
    strb.flagClr = busWr && (busAddr == ADR_STAT) && busWrData[1];
  end

  // R6
  only_one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!shiftClkN && !loadN));

  // R3
  shift_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdShift) |=> !shiftClkN);

  // R4
  load_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdShift && cmdLoad) |=> !loadN);

  // R3
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == '0) |=> (shiftClkN && loadN));

  // R7
  no_load_in_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftClkN && cmdLoad) |=> loadN);
endmodule

// File: rtl/sbw_datapath.sv
module sbw_datapath
  import sbw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sbwStrobes_t       strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              serData,
  output logic [MOD_W-1:0]  modAddr,
  output logic              timer0Gate,
  output logic              sweepTrig,
  output logic              audioEn
);
  logic [DATA_W-1:0] holdReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic              collFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      ctrlReg  <= '0;
      collFlag <= 1'b0;
    end else begin
      if (strb.holdWe) holdReg <= busWrData;
      if (strb.ctrlWe) ctrlReg <= busWrData[CTRL_W-1:0];
      if (strb.flagSet)      collFlag <= 1'b1;
      else if (strb.flagClr) collFlag <= 1'b0;
    end
  end

  assign serData    = holdReg[0];
  assign modAddr    = holdReg[DATA_W-1 -: MOD_W];
  assign timer0Gate = ctrlReg[0];
  assign sweepTrig  = ctrlReg[1];
  assign audioEn    = ctrlReg[2];

  always_comb begin
    case (busAddr)
      ADR_HOLD: busRdData = holdReg;
      ADR_CTRL: busRdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlReg};
      ADR_STAT: busRdData = {{(DATA_W-2){1'b0}}, collFlag, busy};
      default:  busRdData = '0;
    endcase
  end

  // R2
  hold_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdWe |=> (serData == $past(busWrData[0])) &&
                    (modAddr == $past(busWrData[DATA_W-1 -: MOD_W])));

  // R5
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWe |=> (sweepTrig == $past(busWrData[1])));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagSet |=> collFlag);

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.holdWe |=> $stable(holdReg));
endmodule

// File: rtl/serial_bus_writer.sv
module serial_bus_writer
  import sbw_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWr,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  output logic        serData,
  output logic        shiftClkN,
  output logic [3:0]  modAddr,
  output logic        loadN,
  output logic        timer0Gate,
  output logic        sweepTrig,
  output logic        audioEn
);
  sbwStrobes_t strb;
  logic busy;

  sbw_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .strb(strb), .shiftClkN(shiftClkN),
    .loadN(loadN), .busy(busy)
  );

  sbw_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .serData(serData),
    .modAddr(modAddr), .timer0Gate(timer0Gate), .sweepTrig(sweepTrig),
    .audioEn(audioEn)
  );
endmodule

// File: tb/serial_bus_writer_bench.sv
module serial_bus_writer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       serData, shiftClkN, loadN, timer0Gate, sweepTrig, audioEn;
  logic [3:0] modAddr;

  int errors = 0;
  int checks = 0;
  logic [7:0] rxShift = '0;
  logic [7:0] rxLatch = '0;
  logic [3:0] rxAddr  = '0;

  always #2 clk = ~clk;

  serial_bus_writer u_serial_bus_writer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .serData(serData),
    .shiftClkN(shiftClkN), .modAddr(modAddr), .loadN(loadN),
    .timer0Gate(timer0Gate), .sweepTrig(sweepTrig), .audioEn(audioEn)
  );

  // bench-side module model: shift on strobe end, latch on load end
  always @(posedge shiftClkN) if (rstN) rxShift <= {rxShift[6:0], serData};
  always @(posedge loadN) if (rstN) begin rxLatch <= rxShift; rxAddr <= modAddr; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] v);
    busAddr = a; #1; v = busRdData;
  endtask

  task automatic measureLow(input bit useLoad, output int n);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if ((useLoad ? loadN : shiftClkN) == 1'b0) n++;
      else break;
      @(negedge clk);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic [3:0] a);
    for (int i = 7; i >= 0; i--) begin
      busWrite(3'd0, {7'd0, b[i]});
      busWrite(3'd1, 8'h00);
      repeat (3) @(negedge clk);
    end
    busWrite(3'd0, {a, 4'h0});
    busWrite(3'd2, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(shiftClkN && loadN, "R1 pulses idle", {shiftClkN, loadN}, 3);
    check({serData, modAddr, timer0Gate, sweepTrig, audioEn} == '0, "R1 outputs",
          {serData, modAddr, timer0Gate, sweepTrig, audioEn}, 0);
    readReg(3'd0, rd); check(rd == 0, "R1 hold", rd, 0);
    readReg(3'd3, rd); check(rd == 0, "R1 ctrl", rd, 0);
    readReg(3'd4, rd); check(rd == 0, "R1 status", rd, 0);
    @(negedge clk);

    // R2 exhaustive holding sweep
    for (int v = 0; v < 256; v++) begin
      busWrite(3'd0, 8'(v));
      check(serData == v[0], "R2 serData", serData, v[0]);
      check(modAddr == 4'(v >> 4), "R2 modAddr", modAddr, v >> 4);
      readReg(3'd0, rd); check(rd == 8'(v), "R2 readback", rd, v);
      @(negedge clk);
    end

    // R5 exhaustive control sweep (upper bits set to show they are dropped)
    for (int v = 0; v < 8; v++) begin
      busWrite(3'd3, 8'(v) | 8'hF8);
      check(timer0Gate == v[0], "R5 timer0Gate", timer0Gate, v[0]);
      check(sweepTrig == v[1], "R5 sweepTrig", sweepTrig, v[1]);
      check(audioEn == v[2], "R5 audioEn", audioEn, v[2]);
      readReg(3'd3, rd); check(rd == 8'(v), "R5 readback", rd, v);
      @(negedge clk);
    end

    // R3 shift pulse length, R8 busy bit
    busWrite(3'd1, 8'h00);
    readReg(3'd4, rd); check(rd == 8'h01, "R8 busy during pulse", rd, 1);
    check(loadN == 1'b1, "R6 load idle during shift", loadN, 1);
    measureLow(1'b0, n); check(n == 2, "R3 shift low cycles", n, 2);
    readReg(3'd4, rd); check(rd == 8'h00, "R8 busy cleared", rd, 0);

    // R4 load pulse length
    busWrite(3'd2, 8'h00);
    check(shiftClkN == 1'b1, "R6 shift idle during load", shiftClkN, 1);
    measureLow(1'b1, n); check(n == 2, "R4 load low cycles", n, 2);

    // R7 collision in first and last pulse cycle
    busWrite(3'd1, 8'h00);
    busWrite(3'd2, 8'h00);
    check(!shiftClkN && loadN, "R7 load ignored mid-shift", {shiftClkN, loadN}, 1);
    busWrite(3'd1, 8'h00);
    check(shiftClkN && loadN, "R7 shift not extended", {shiftClkN, loadN}, 3);
    @(negedge clk);
    check(shiftClkN && loadN, "R7 still idle", {shiftClkN, loadN}, 3);
    readReg(3'd4, rd); check(rd == 8'h02, "R8 collision flag", rd, 2);
    busWrite(3'd4, 8'h01);
    readReg(3'd4, rd); check(rd == 8'h02, "R8 bit0 write keeps flag", rd, 2);
    busWrite(3'd4, 8'h02);
    readReg(3'd4, rd); check(rd == 8'h00, "R8 flag cleared", rd, 0);
    @(negedge clk);

    // R9 unused addresses
    busWrite(3'd0, 8'h5A);
    busWrite(3'd3, 8'h05);
    for (int a = 5; a < 8; a++) begin
      busWrite(3'(a), 8'hFF);
      @(negedge clk);
      check(shiftClkN && loadN, "R9 no pulse", {shiftClkN, loadN}, 3);
      readReg(3'(a), rd); check(rd == 0, "R9 read zero", rd, 0);
    end
    readReg(3'd1, rd); check(rd == 0, "R9 read strobe addr", rd, 0);
    readReg(3'd2, rd); check(rd == 0, "R9 read load addr", rd, 0);
    readReg(3'd0, rd); check(rd == 8'h5A, "R9 hold kept", rd, 8'h5A);
    readReg(3'd3, rd); check(rd == 8'h05, "R9 ctrl kept", rd, 5);
    check({timer0Gate, sweepTrig, audioEn} == 3'b101, "R9 ctrl outputs kept",
          {audioEn, sweepTrig, timer0Gate}, 5);
    @(negedge clk);

    // R2/R3/R4 full transfers into a modeled module
    sendByte(8'hA5, 4'h9);
    check(rxLatch == 8'hA5, "R3 transfer data", rxLatch, 8'hA5);
    check(rxAddr == 4'h9, "R4 transfer addr", rxAddr, 9);
    sendByte(8'h3C, 4'hE);
    check(rxLatch == 8'h3C, "R3 transfer data 2", rxLatch, 8'h3C);
    check(rxAddr == 4'hE, "R4 transfer addr 2", rxAddr, 14);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule